// File: doc/BRIEF.md
# Framed Register-Job Responder

This block is a slave that serves a bank of small registers through two framed byte streams. Jobs arrive on an input stream that uses valid and accept handshakes and marks its frames with start and stop flags. Each job opens with a header byte. The command sits in the header's lower bits and the register address in its upper bits. A read job is a single beat that carries both start and stop. A write job is a header beat without stop, followed by a data beat that carries stop.

The block replies to every well-formed job on an output stream built the same way. The first reply beat echoes the header and carries start. A read reply then sends one data beat. Every reply ends with a status footer beat that carries stop. A header with an unknown command, or with the wrong flags for its command, is dropped without any reply. An address beyond the bank is still answered, and its footer reports the error.

While a job is being answered, the input side refuses new beats. Jobs are therefore handled one at a time, and their order is kept.

Top module: `regjob_responder`

## Requirements
- R1: The header byte splits into two nibbles. Bits 3:0 hold the command, where 0 means read and 1 means write. Bits 7:4 hold the register address.
- R2: A header beat (valid and start) whose command is neither 0 nor 1 is dropped. No output beat follows, and input accept returns high within a few cycles.
- R3: A read header that does not carry stop is dropped without a reply.
- R4: A write header that carries stop is dropped without a reply, and the registers are left as they were. After a write header without stop, accepted beats that lack stop are consumed and ignored. The first accepted beat with stop supplies the write data.
- R5: A read reply is exactly three beats. The first carries start only and echoes the header byte. The second carries neither flag and holds the register value. The third carries stop only.
- R6: A write reply is exactly two beats. The first carries start only and echoes the header byte. The second carries stop only.
- R7: The footer byte is 0x00 on success and 0x01 on an address error. Any address of 8 or above is an error. A read of such an address returns data 0x00, and a write to it changes no register.
- R8: An output beat keeps its valid, start, stop and data unchanged until it is accepted. Start and stop never appear on the same beat.
- R9: Input accept is low from the moment a job is complete until its footer beat has been accepted.
- R10: Reset is synchronous and active low. It clears every register to 0x00 and leaves no output beat pending.
- R11: While the block waits for a header, an input beat without start is consumed and ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_start | input | 1 | Input beat opens a job |
| in_stop | input | 1 | Input beat closes a job |
| in_data | input | 8 | Input beat byte |
| in_accept | output | 1 | Block takes the input beat this cycle |
| out_valid | output | 1 | Reply beat present |
| out_start | output | 1 | Reply beat opens a reply |
| out_stop | output | 1 | Reply beat closes a reply |
| out_data | output | 8 | Reply beat byte |
| out_accept | input | 1 | Receiver takes the reply beat this cycle |

## Verification
A controller that takes a wrong branch at the header shows up at the ports within a few cycles. It either produces a reply to a job that should have been dropped, or it never raises input accept again. A wrongly stored header or error flag shows up as a mismatched echo byte or footer byte in that same reply. A register-bank fault can stay hidden until a later read of the affected address. For that reason, every address is written with a distinct value and then read back, including the out-of-range addresses. The reads are repeated after the dropped jobs and again after a reset.

// File: rtl/regjob_pkg.sv
package regjob_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GET_HDR,
      ST_GET_DATA,
      ST_SET_DATA,
      ST_SEND_HDR,
      ST_SEND_DATA,
      ST_SEND_FTR
   } rj_state_e;

   localparam int unsigned RJ_CMD_READ  = 0;
   localparam int unsigned RJ_CMD_WRITE = 1;

endpackage

// File: rtl/regjob_hdr_decode.sv
module regjob_hdr_decode #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CMD_W    = 4,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned NUM_REGS = 8,
   localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic [DATA_W-1:0] hdr,
   output logic              is_read,
   output logic              is_write,
   output logic              addr_ok,
   output logic [IDX_W-1:0]  idx
);
   import regjob_pkg::*;

   logic [CMD_W-1:0]  cmd;
   logic [ADDR_W-1:0] addr;

   assign cmd      = hdr[CMD_W-1:0];
   assign addr     = hdr[CMD_W +: ADDR_W];
   assign is_read  = (cmd == CMD_W'(RJ_CMD_READ));
   assign is_write = (cmd == CMD_W'(RJ_CMD_WRITE));
   assign idx      = addr[IDX_W-1:0];

   generate
      if (NUM_REGS == (1 << ADDR_W)) begin : g_full_space
         assign addr_ok = 1'b1;
      end else begin : g_partial_space
         localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);
         assign addr_ok = ({1'b0, addr} < LIMIT);
      end
   endgenerate

endmodule

// File: rtl/regjob_regbank.sv
module regjob_regbank #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NUM_REGS = 8,
   localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem [NUM_REGS];

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mem[g] <= '0;
            end else if (wr_en && (idx == IDX_W'(g))) begin
               mem[g] <= wr_data;
            end
         end
      end
   endgenerate

   assign rd_data = mem[idx];

   // R4: an accepted write lands in the addressed cell
   assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mem[$past(idx)] == $past(wr_data)));

endmodule

// File: rtl/regjob_ctrl.sv
module regjob_ctrl #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NUM_REGS = 8,
   localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_start,
   input  logic              in_stop,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_accept,
   output logic              out_valid,
   output logic              out_start,
   output logic              out_stop,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_accept,
   output logic [DATA_W-1:0] dec_hdr,
   input  logic              dec_is_read,
   input  logic              dec_is_write,
   input  logic              dec_addr_ok,
   output logic              reg_we,
   output logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] reg_rdata
);
   import regjob_pkg::*;

   rj_state_e         state;
   logic [DATA_W-1:0] hdr_q;
   logic [DATA_W-1:0] data_q;
   logic              err_q;
   logic              hdr_beat;
   logic              stop_beat;

   assign hdr_beat  = (state == ST_GET_HDR) && in_valid && in_start;
   assign stop_beat = (state == ST_SET_DATA) && in_valid && in_stop;

   // live header while waiting for one, held header afterwards
   assign dec_hdr   = (state == ST_GET_HDR) ? in_data : hdr_q;
   assign in_accept = (state == ST_GET_HDR) || (state == ST_SET_DATA);
   assign reg_we    = stop_beat && dec_addr_ok;
   assign reg_wdata = in_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         hdr_q  <= '0;
         data_q <= '0;
         err_q  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: state <= ST_GET_HDR;
            ST_GET_HDR: begin
               if (hdr_beat) begin
                  hdr_q <= in_data;
                  err_q <= 1'b0;
                  if (dec_is_read && in_stop) begin
                     state <= ST_GET_DATA;
                  end else if (dec_is_write && !in_stop) begin
                     state <= ST_SET_DATA;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_GET_DATA: begin
               data_q <= dec_addr_ok ? reg_rdata : '0;
               err_q  <= !dec_addr_ok;
               state  <= ST_SEND_HDR;
            end
            ST_SET_DATA: begin
               if (stop_beat) begin
                  err_q <= !dec_addr_ok;
                  state <= ST_SEND_HDR;
               end
            end
            ST_SEND_HDR: begin
               if (out_accept) begin
                  state <= dec_is_read ? ST_SEND_DATA : ST_SEND_FTR;
               end
            end
            ST_SEND_DATA: begin
               if (out_accept) state <= ST_SEND_FTR;
            end
            ST_SEND_FTR: begin
               if (out_accept) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      out_valid = 1'b0;
      out_start = 1'b0;
      out_stop  = 1'b0;
      out_data  = '0;
      case (state)
         ST_SEND_HDR: begin
            out_valid = 1'b1;
            out_start = 1'b1;
            out_data  = hdr_q;
         end
         ST_SEND_DATA: begin
            out_valid = 1'b1;
            out_data  = data_q;
         end
         ST_SEND_FTR: begin
            out_valid = 1'b1;
            out_stop  = 1'b1;
            out_data  = {{(DATA_W-1){1'b0}}, err_q};
         end
         default: ;
      endcase
   end

   // R2: unknown command returns to idle with no reply
   assert_bad_cmd_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_beat && !dec_is_read && !dec_is_write) |=> (state == ST_IDLE) && !out_valid);

   // R3: read header lacking stop is dropped
   assert_read_nostop_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_beat && dec_is_read && !in_stop) |=> (state == ST_IDLE) && !out_valid);

   // R4: write header with stop is dropped
   assert_write_stop_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_beat && dec_is_write && in_stop) |=> (state == ST_IDLE) && !out_valid);

   // R8: pending reply beat is held until taken
   assert_beat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_accept) |=> out_valid && $stable(out_start)
                                     && $stable(out_stop) && $stable(out_data));

   // R6: an accepted write reply header is followed by the footer
   assert_write_reply_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_start && out_accept && dec_is_write) |=> out_valid && out_stop);

   // R9: no input taken while a reply is outstanding
   assert_no_intake_during_reply_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_accept);

endmodule

// File: rtl/regjob_responder.sv
module regjob_responder #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CMD_W    = 4,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned NUM_REGS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_start,
   input  logic              in_stop,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_accept,
   output logic              out_valid,
   output logic              out_start,
   output logic              out_stop,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_accept
);

   localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   generate
      if (CMD_W + ADDR_W != DATA_W) begin : g_bad_split
         $error("header fields must fill the data byte exactly");
      end
      if ((NUM_REGS < 2) || (NUM_REGS > (1 << ADDR_W))) begin : g_bad_depth
         $error("register count must fit the address field");
      end
   endgenerate

   logic [DATA_W-1:0] dec_hdr;
   logic              dec_is_read;
   logic              dec_is_write;
   logic              dec_addr_ok;
   logic [IDX_W-1:0]  dec_idx;
   logic              reg_we;
   logic [DATA_W-1:0] reg_wdata;
   logic [DATA_W-1:0] reg_rdata;

   regjob_hdr_decode #(
      .DATA_W(DATA_W), .CMD_W(CMD_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)
   ) u_dec (
      .hdr(dec_hdr), .is_read(dec_is_read), .is_write(dec_is_write),
      .addr_ok(dec_addr_ok), .idx(dec_idx)
   );

   regjob_regbank #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .idx(dec_idx),
      .wr_data(reg_wdata), .rd_data(reg_rdata)
   );

   regjob_ctrl #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_start(in_start), .in_stop(in_stop),
      .in_data(in_data), .in_accept(in_accept),
      .out_valid(out_valid), .out_start(out_start), .out_stop(out_stop),
      .out_data(out_data), .out_accept(out_accept),
      .dec_hdr(dec_hdr), .dec_is_read(dec_is_read), .dec_is_write(dec_is_write),
      .dec_addr_ok(dec_addr_ok),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

endmodule

// File: tb/sim_regjob_responder.sv
module sim_regjob_responder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0, in_start = 1'b0, in_stop = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_accept;
   logic       out_valid, out_start, out_stop;
   logic [7:0] out_data;
   logic       out_accept = 1'b0;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   regjob_responder u0 (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_start(in_start), .in_stop(in_stop),
      .in_data(in_data), .in_accept(in_accept),
      .out_valid(out_valid), .out_start(out_start), .out_stop(out_stop),
      .out_data(out_data), .out_accept(out_accept)
   );

   function automatic logic [7:0] pattern(input int a);
      return 8'((a * 37 + 5) & 255);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic s, input logic p, input logic [7:0] d);
      int guard = 0;
      @(negedge clk);
      in_valid = 1'b1; in_start = s; in_stop = p; in_data = d;
      while (!in_accept && guard < 500) begin
         @(negedge clk);
         guard++;
      end
      if (!in_accept) chk(1'b0, "R9", "input accept never returned", 0, 1);
      @(posedge clk);
      #1;
      in_valid = 1'b0; in_start = 1'b0; in_stop = 1'b0;
   endtask

   task automatic get_beat(input int stall, output logic s, output logic p,
                           output logic [7:0] d);
      int guard = 0;
      @(negedge clk);
      while (!out_valid && guard < 200) begin
         @(negedge clk);
         guard++;
      end
      if (!out_valid) begin
         chk(1'b0, "R5", "reply beat missing", 0, 1);
         s = 1'b0; p = 1'b0; d = 8'h00;
         return;
      end
      s = out_start; p = out_stop; d = out_data;
      chk(!in_accept, "R9", "input accept during reply", int'(in_accept), 0);
      chk(!(s && p), "R8", "start and stop together", 1, 0);
      for (int i = 0; i < stall; i++) begin
         @(negedge clk);
         chk(out_valid && out_start == s && out_stop == p && out_data == d,
             "R8", "beat changed while stalled", int'(out_data), int'(d));
         chk(!in_accept, "R9", "input accept during stalled reply", int'(in_accept), 0);
      end
      out_accept = 1'b1;
      @(posedge clk);
      #1;
      out_accept = 1'b0;
   endtask

   task automatic do_read(input int a, input int stall, input logic [7:0] exp_d,
                          input logic [7:0] exp_f);
      logic s, p;
      logic [7:0] d;
      logic [7:0] hdr;
      hdr = {4'(a), 4'h0};
      push(1'b1, 1'b1, hdr);
      get_beat(stall, s, p, d);
      chk(s && !p && d == hdr, "R5", "read reply header echo (R1 decode)", int'(d), int'(hdr));
      get_beat(stall, s, p, d);
      chk(!s && !p && d == exp_d, "R5", "read data beat", int'(d), int'(exp_d));
      get_beat(stall, s, p, d);
      chk(!s && p && d == exp_f, "R7", "read footer", int'(d), int'(exp_f));
   endtask

   task automatic do_write(input int a, input logic [7:0] v, input int nfill,
                           input int stall, input logic [7:0] exp_f);
      logic s, p;
      logic [7:0] d;
      logic [7:0] hdr;
      hdr = {4'(a), 4'h1};
      push(1'b1, 1'b0, hdr);
      for (int i = 0; i < nfill; i++) push(1'b0, 1'b0, 8'hEE);
      push(1'b0, 1'b1, v);
      get_beat(stall, s, p, d);
      chk(s && !p && d == hdr, "R6", "write reply header echo", int'(d), int'(hdr));
      get_beat(stall, s, p, d);
      chk(!s && p && d == exp_f, "R7", "write footer", int'(d), int'(exp_f));
   endtask

   task automatic check_silent(input string req);
      int bad = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (out_valid) bad++;
      end
      chk(bad == 0, req, "reply to dropped beat", bad, 0);
      chk(in_accept == 1'b1, req, "input accept after drop", int'(in_accept), 1);
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      apply_reset();
      @(negedge clk);
      chk(!out_valid, "R10", "no reply after reset", int'(out_valid), 0);

      // R10: registers start at zero
      for (int a = 0; a < 8; a++) do_read(a, 0, 8'h00, 8'h00);

      // R4 R7: write every address, fillers and stalls varied
      for (int a = 0; a < 16; a++)
         do_write(a, pattern(a), a % 3, a % 4, (a > 7) ? 8'h01 : 8'h00);

      // R5 R7: read every address back
      for (int a = 0; a < 16; a++)
         do_read(a, (a + 1) % 3, (a < 8) ? pattern(a) : 8'h00,
                 (a > 7) ? 8'h01 : 8'h00);

      // R2: every unknown command is dropped
      for (int c = 2; c < 16; c++) begin
         push(1'b1, 1'(c & 1), {4'(c % 8), 4'(c)});
         check_silent("R2");
      end
      do_read(3, 1, pattern(3), 8'h00);

      // R3: read header without stop
      push(1'b1, 1'b0, {4'd2, 4'h0});
      check_silent("R3");
      do_read(2, 0, pattern(2), 8'h00);

      // R4: write header carrying stop leaves the register alone
      push(1'b1, 1'b1, {4'd5, 4'h1});
      check_silent("R4");
      do_read(5, 0, pattern(5), 8'h00);

      // R11: beat without start while waiting for a header
      push(1'b0, 1'b1, {4'd1, 4'h0});
      check_silent("R11");
      do_read(1, 2, pattern(1), 8'h00);

      // R10: reset clears written contents
      do_write(2, 8'hA5, 0, 0, 8'h00);
      do_read(2, 0, 8'hA5, 8'h00);
      apply_reset();
      @(negedge clk);
      chk(!out_valid, "R10", "no reply after second reset", int'(out_valid), 0);
      do_read(2, 0, 8'h00, 8'h00);
      do_read(7, 0, 8'h00, 8'h00);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule